// File: doc/BRIEF.md
# Serial Flash Array Read Responder (Single and Dual Output)

This block is the target-side read path of a serial NOR flash. A host selects it with an active-low select line, toggles a serial clock and shifts a command in on I/O0. Two commands are understood. The first is a plain read: eight opcode bits, then a 24-bit start address, then one data bit per clock on I/O1. The second is a dual-output read: the same header plus eight dummy clocks, then two data bits per clock on I/O1 and I/O0. Either read runs through consecutive addresses for as long as the host keeps clocking, and it wraps from the highest array address back to zero without a gap.

The block runs on a fast system clock. It samples select, serial clock and I/O0 through short synchronisers, so the serial clock must be several system clocks per half period. It works with serial-clock idle low and with idle high. Each pin has its own output-enable for an external tri-state pad. The byte array is an inferable block RAM that is filled through a simple write port before traffic starts. Array address bits above the array width are discarded, and this discarding produces the wrap.

Top module: `sflash_rd_resp`

## Requirements
- R1: Opcode 03h, then a 24-bit address sent MSB first, makes the block return array bytes on io1_o MSB first, one bit per serial clock, starting at that address. io0_oe stays low throughout.
- R2: Opcode 3Bh, then the 24-bit address and exactly eight further dummy clocks, starts a dual read. Neither output enable is asserted while opcode, address or dummy bits are being received.
- R3: In a dual read each serial clock delivers two bits of the current byte: bits 7/6 first, then 5/4, 3/2 and 1/0, with the higher bit on io1_o and the lower on io0_o. A complete byte therefore takes four clocks.
- R4: io0_oe is asserted only in the data phase of a dual read, and only together with io1_oe.
- R5: Each byte is read from the address after the previous byte's. After address 2^MEM_AW-1 the next byte comes from address 0 with no extra clocks. Address bits at MEM_AW and above are ignored.
- R6: Releasing chip select at any point, including in the middle of a byte, drops both output enables within three system clocks.
- R7: Input bits are taken on rising serial-clock edges. Output bits change only after falling edges and hold through the following rising edge. Both idle-low and idle-high clock polarity work.
- R8: Any opcode other than 03h and 3Bh is ignored: no output enable is asserted until select is released. The next selection decodes normally.
- R9: Every new select restarts the opcode, address and bit counters, so a command aborted part way through has no effect on the next one.
- R10: A write on the load port (ld_we with ld_addr and ld_data) stores the byte, and later reads return it.
- R11: After synchronous reset both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| io0_i | input | 1 | Serial data in (command, address, dummy) |
| io0_o | output | 1 | Low data bit in dual data phase |
| io0_oe | output | 1 | Output enable for the I/O0 pad |
| io1_o | output | 1 | Serial data out; high bit in dual mode |
| io1_oe | output | 1 | Output enable for the I/O1 pad |
| ld_we | input | 1 | Array preload write strobe |
| ld_addr | input | MEM_AW | Array preload address |
| ld_data | input | 8 | Array preload byte |

## Verification
The assertions assume that the serial clock is slow against the system clock, that select changes only while the serial clock is steady for at least one half period, and that no input toggles during reset. The stimulus holds every serial-clock level for eight system clocks and changes select and I/O0 only in the middle of a level. It drives all inputs on the falling system-clock edge. The preload port is used only while select is released, so reads never overlap a write to the same byte.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_DREAD = 8'h3B;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGNORE
  } phase_e;

endpackage

// File: rtl/sfr_sync.sv
// Brings the host pins into the system clock domain and marks serial-clock edges.
module sfr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic io0_i,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic si
);

  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] d_q;
  logic              sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= '1;
      sck_q    <= '0;
      d_q      <= '0;
      sck_last <= 1'b0;
    end else begin
      cs_q     <= {cs_q[STAGES-2:0], cs_n};
      sck_q    <= {sck_q[STAGES-2:0], sck};
      d_q      <= {d_q[STAGES-2:0], io0_i};
      sck_last <= sck_q[TOP];
    end
  end

  assign sel      = ~cs_q[TOP];
  assign sck_rise = sck_q[TOP] & ~sck_last;
  assign sck_fall = ~sck_q[TOP] & sck_last;
  assign si       = d_q[TOP];

endmodule

// File: rtl/sfr_cmd.sv
// Counts rising edges in a selection and decodes opcode, address and dummy phases.
module sfr_cmd
  import sfr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int OUT_W   = 8,
  parameter int DUMMY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             rise,
  input  logic             si,
  output phase_e           phase,
  output logic             dual,
  output logic [OUT_W-1:0] addr,
  output logic             go
);

  localparam int OPC_BITS  = 8;
  localparam int ADDR_END  = OPC_BITS + ADDR_W;
  localparam int DUMMY_END = ADDR_END + DUMMY_W;
  localparam int CNT_W     = $clog2(DUMMY_END + 1);
  localparam int SH_W      = ((OUT_W > OPC_BITS) ? OUT_W : OPC_BITS) - 1;

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  logic [SH_W:0]    nxt;

  assign nxt = {sh, si};

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      phase <= PH_OPC;
      cnt   <= '0;
      sh    <= '0;
      dual  <= 1'b0;
      addr  <= '0;
      go    <= 1'b0;
    end else begin
      go <= 1'b0;
      if (rise) begin
        unique case (phase)
          PH_OPC: begin
            sh  <= nxt[SH_W-1:0];
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(OPC_BITS - 1)) begin
              if (nxt[7:0] == OPC_READ) begin
                phase <= PH_ADDR;
                dual  <= 1'b0;
              end else if (nxt[7:0] == OPC_DREAD) begin
                phase <= PH_ADDR;
                dual  <= 1'b1;
              end else begin
                phase <= PH_IGNORE;
              end
            end
          end
          PH_ADDR: begin
            sh  <= nxt[SH_W-1:0];
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(ADDR_END - 1)) begin
              addr <= nxt[OUT_W-1:0];
              if (dual) begin
                phase <= PH_DUMMY;
              end else begin
                phase <= PH_DATA;
                go    <= 1'b1;
              end
            end
          end
          PH_DUMMY: begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(DUMMY_END - 1)) begin
              phase <= PH_DATA;
              go    <= 1'b1;
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sfr_ram.sv
// Byte array with one write port and one registered read port.
module sfr_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/sfr_tx.sv
// Keeps one byte prefetched and serialises it on falling serial-clock edges.
module sfr_tx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          fall,
  input  logic          en,
  input  logic          dual,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    rdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          io1_o,
  output logic          io1_oe,
  output logic          io0_o,
  output logic          io0_oe
);

  localparam logic [2:0] LAST_SINGLE = 3'd7;
  localparam logic [2:0] LAST_DUAL   = 3'd3;

  logic [AW-1:0] ptr;
  logic [2:0]    beat;
  logic [2:0]    last;
  logic [7:0]    shreg;
  logic [7:0]    cur;
  logic          fetch;

  assign cur  = (beat == 3'd0) ? rdata : shreg;
  assign last = dual ? LAST_DUAL : LAST_SINGLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      beat   <= '0;
      shreg  <= '0;
      fetch  <= 1'b0;
      io1_o  <= 1'b0;
      io0_o  <= 1'b0;
      io1_oe <= 1'b0;
      io0_oe <= 1'b0;
    end else begin
      fetch <= 1'b0;
      if (!sel) begin
        io1_oe <= 1'b0;
        io0_oe <= 1'b0;
        beat   <= '0;
      end else if (go) begin
        ptr   <= start_addr;
        fetch <= 1'b1;
        beat  <= '0;
      end else if (en && fall) begin
        io1_o  <= cur[7];
        io1_oe <= 1'b1;
        io0_oe <= dual;
        if (dual) begin
          io0_o <= cur[6];
          shreg <= {cur[5:0], 2'b00};
        end else begin
          shreg <= {cur[6:0], 1'b0};
        end
        beat <= (beat == last) ? 3'd0 : beat + 3'd1;
        if (beat == 3'd0) begin
          ptr   <= ptr + 1'b1;
          fetch <= 1'b1;
        end
      end
    end
  end

  assign rd_en   = fetch;
  assign rd_addr = ptr;

endmodule

// File: rtl/sflash_rd_resp.sv
module sflash_rd_resp #(
  parameter int MEM_AW      = 8,
  parameter int ADDR_W      = 24,
  parameter int DUMMY_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              io0_i,
  output logic              io0_o,
  output logic              io0_oe,
  output logic              io1_o,
  output logic              io1_oe,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [7:0]        ld_data
);

  import sfr_pkg::*;

  logic              sel;
  logic              sck_rise;
  logic              sck_fall;
  logic              si;
  phase_e            phase;
  logic              dual;
  logic [MEM_AW-1:0] start_addr;
  logic              go;
  logic              rd_en;
  logic [MEM_AW-1:0] rd_addr;
  logic [7:0]        rdata;
  logic              in_data;

  assign in_data = (phase == PH_DATA);

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .io0_i    (io0_i),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si       (si)
  );

  sfr_cmd #(.ADDR_W(ADDR_W), .OUT_W(MEM_AW), .DUMMY_W(DUMMY_W)) u_cmd (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .rise  (sck_rise),
    .si    (si),
    .phase (phase),
    .dual  (dual),
    .addr  (start_addr),
    .go    (go)
  );

  sfr_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rdata)
  );

  sfr_tx #(.AW(MEM_AW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .fall       (sck_fall),
    .en         (in_data),
    .dual       (dual),
    .go         (go),
    .start_addr (start_addr),
    .rdata      (rdata),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .io1_o      (io1_o),
    .io1_oe     (io1_oe),
    .io0_o      (io0_o),
    .io0_oe     (io0_oe)
  );

endmodule

// File: rtl/sfr_chk.sv
module sfr_chk
  import sfr_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   sel,
  input logic   fall,
  input phase_e phase,
  input logic   dual,
  input logic   io1_o,
  input logic   io0_o,
  input logic   io1_oe,
  input logic   io0_oe
);

  // R6: a released select silences both pads on the next clock
  p_hiz_desel_r6: assert property (@(posedge clk) disable iff (rst)
    !sel |=> (!io1_oe && !io0_oe));

  // R4: the low pad is only driven alongside the high pad in dual mode
  p_io0_dual_only_r4: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> (io1_oe && dual));

  // R1: a single-bit read never drives I/O0
  p_single_no_io0_r1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DATA && !dual) |-> !io0_oe);

  // R2, R8: no drive outside the data phase (header, dummy, unknown opcode)
  p_quiet_outside_data_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_DATA) |-> (!io1_oe && !io0_oe));

  // R7: output bits only move on a detected falling serial-clock edge
  p_edge_launch_r7: assert property (@(posedge clk) disable iff (rst)
    !fall |=> ($stable(io1_o) && $stable(io0_o)));

endmodule

bind sflash_rd_resp sfr_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .sel    (sel),
  .fall   (sck_fall),
  .phase  (phase),
  .dual   (dual),
  .io1_o  (io1_o),
  .io0_o  (io0_o),
  .io1_oe (io1_oe),
  .io0_oe (io0_oe)
);

// File: tb/tb_sflash_rd_resp.sv
module tb_sflash_rd_resp;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 8;
  localparam int DEPTH      = 1 << MEM_AW;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic io0_i = 1'b0;
  logic io0_o, io0_oe, io1_o, io1_oe;
  logic ld_we = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  logic pre_drive;
  logic oe_bad;
  logic hold_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_rd_resp #(.MEM_AW(MEM_AW)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .io0_i(io0_i),
    .io0_o(io0_o), .io0_oe(io0_oe), .io1_o(io1_o), .io1_oe(io1_oe),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] a, input int k);
    return model[(int'(a) + k) % DEPTH];
  endfunction

  task automatic load(input int a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = MEM_AW'(a); ld_data = d;
    wclk(1);
    ld_we = 1'b0;
    model[a] = d;
  endtask

  // one host-driven bit: data set while low, taken on the rising edge
  task automatic sck_bit(input logic b);
    io0_i = b;
    wclk(HALF);
    if (io1_oe || io0_oe) pre_drive = 1'b1;
    sck = 1'b1;
    wclk(HALF);
    if (io1_oe || io0_oe) pre_drive = 1'b1;
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sck_bit(v[i]);
  endtask

  task automatic begin_txn(input logic mode3);
    sck = mode3;
    wclk(HALF);
    cs_n = 1'b0;
    wclk(HALF);
    if (mode3) sck = 1'b0;
    pre_drive = 1'b0;
  endtask

  task automatic end_txn(input logic mode3, input string req);
    wclk(HALF);
    if (mode3) begin
      sck = 1'b1;
      wclk(HALF);
    end
    cs_n = 1'b1;
    wclk(4);
    chk(!io1_oe && !io0_oe, req, "output enables after select release",
        {io1_oe, io0_oe}, 0);
    wclk(HALF);
  endtask

  task automatic read_beat(input logic dualm, output logic b1, output logic b0);
    io0_i = 1'b0;
    wclk(HALF);
    b1 = io1_o;
    b0 = io0_o;
    if (!io1_oe || (io0_oe != dualm)) oe_bad = 1'b1;
    sck = 1'b1;
    wclk(HALF);
    if (io1_o != b1 || (dualm && io0_o != b0)) hold_bad = 1'b1;
    sck = 1'b0;
  endtask

  task automatic do_read(input logic dualm, input logic mode3,
                         input logic [23:0] a, input int n, input int part,
                         input string req);
    logic b1, b0;
    logic [7:0] got;
    begin_txn(mode3);
    send_byte(dualm ? 8'h3B : 8'h03);
    for (int i = 23; i >= 0; i--) sck_bit(a[i]);
    if (dualm) send_byte(8'($urandom));
    // R2: no pad driven during the header
    chk(!pre_drive, "R2", "drive during opcode/address/dummy", pre_drive, 0);
    oe_bad = 1'b0;
    hold_bad = 1'b0;
    for (int k = 0; k < n; k++) begin
      got = '0;
      if (dualm) begin
        for (int j = 0; j < 4; j++) begin
          read_beat(1'b1, b1, b0);
          got = {got[5:0], b1, b0};
        end
      end else begin
        for (int j = 0; j < 8; j++) begin
          read_beat(1'b0, b1, b0);
          got = {got[6:0], b1};
        end
      end
      chk(got == exp_byte(a, k), req, "data byte", got, exp_byte(a, k));
    end
    for (int j = 0; j < part; j++) read_beat(dualm, b1, b0);
    // R4: enables match the mode in every data beat
    chk(!oe_bad, "R4", "output enables during data beats", oe_bad, 0);
    // R7: values hold across the rising edge
    chk(!hold_bad, "R7", "output held through rising edge", hold_bad, 0);
    end_txn(mode3, "R6");
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%0d expected=finish", WD_CYCLES);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wclk(5);
    rst = 1'b0;
    wclk(2);
    // R11: reset state
    chk(!io1_oe && !io0_oe, "R11", "enables after reset", {io1_oe, io0_oe}, 0);

    // R10: preload the array through the load port
    for (int i = 0; i < DEPTH; i++) load(i, 8'($urandom));

    // R1: single reads, idle-low and idle-high clock (R7)
    do_read(1'b0, 1'b0, 24'h000010, 4, 0, "R1");
    do_read(1'b0, 1'b1, 24'h000020, 2, 0, "R1 mode3 R7");
    // R3: dual reads in both polarities
    do_read(1'b1, 1'b0, 24'h000040, 4, 0, "R3");
    do_read(1'b1, 1'b1, 24'h000081, 3, 0, "R3 mode3 R7");
    // R5: wrap at the top of the array, and upper address bits ignored
    do_read(1'b0, 1'b0, 24'h0000FE, 4, 0, "R5 single wrap");
    do_read(1'b1, 1'b0, 24'h0000FF, 3, 0, "R5 dual wrap");
    do_read(1'b1, 1'b1, 24'h1FFFFF, 2, 0, "R5 high address bits");

    // R8: unknown opcode keeps pads quiet, then a normal read works
    begin_txn(1'b0);
    send_byte(8'hA7);
    for (int i = 0; i < 40; i++) sck_bit(1'($urandom));
    chk(!pre_drive, "R8", "drive after unknown opcode", pre_drive, 0);
    end_txn(1'b0, "R8");
    do_read(1'b0, 1'b0, 24'h000033, 1, 0, "R8 decode after ignore");

    // R9: abort partway through the address, then read again
    begin_txn(1'b1);
    send_byte(8'h3B);
    for (int i = 0; i < 10; i++) sck_bit(1'b1);
    end_txn(1'b1, "R9");
    do_read(1'b0, 1'b0, 24'h000055, 2, 0, "R9 fresh command");

    // R6: release select in the middle of a dual byte
    do_read(1'b1, 1'b0, 24'h000070, 1, 2, "R6 prefix");
    // R6: release in the middle of a single byte
    do_read(1'b0, 1'b1, 24'h000090, 1, 5, "R6 prefix");

    // R10: overwrite a byte, then read it back
    load(8'h33, 8'hC5);
    do_read(1'b1, 1'b0, 24'h000033, 1, 0, "R10 reload");

    // mixed random traffic
    for (int t = 0; t < 16; t++) begin
      do_read(1'($urandom), 1'($urandom), 24'($urandom),
              1 + int'($urandom % 3), 0, "R1/R3/R5 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule